// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit forms the effective memory address for a load or store from operand fields that have already been decoded. It takes a base register value, an index register value, a two-bit scale code, a displacement with a size code, an access size code and an addressing-mode select. All address forms share one three-input adder path. For each accepted request, one clock edge later the unit presents three results together: the address, a base-register update value with its enable, and a misalignment flag.

Seven modes are supported:
- absolute (zero plus displacement)
- register-indirect
- base plus displacement
- base plus index
- base plus scaled index plus displacement
- post-increment, which addresses at the base and updates the base by one
- pre-indexed update, which addresses at base plus displacement and writes that same sum back

The displacement field is sign-extended from 8, 16 or 32 bits before the add. The misalignment flag is only advisory: the address is always produced.

Top module: `addr_gen_unit`

## Requirements
- R1: Outputs are registered. `out_valid` equals the `in_valid` of the previous cycle. While `rst` is high, `out_valid`, `wb_en`, `align_fault`, `eff_addr` and `wb_value` are all zero on the next edge.
- R2: Mode code 0 (absolute) gives `eff_addr` = sign-extended displacement.
- R3: Mode code 1 (register-indirect) gives `eff_addr` = `base`.
- R4: Mode code 2 (base plus displacement) gives `eff_addr` = `base` + sign-extended displacement.
- R5: Mode code 3 (indexed) gives `eff_addr` = `base` + `index`, and the scale code has no effect.
- R6: Mode code 4 (scaled) gives `eff_addr` = `base` + (`index` << `scale`) + sign-extended displacement, which is a factor of 1, 2, 4 or 8.
- R7: Displacement size code 0 sign-extends `disp[7:0]`, code 1 sign-extends `disp[15:0]`, code 2 uses all 32 bits, and code 3 contributes zero.
- R8: Mode code 5 (post-increment) gives `eff_addr` = `base`, `wb_value` = `base` + 1 and `wb_en` = 1.
- R9: Mode code 6 (pre-indexed update) gives `eff_addr` = `base` + displacement, `wb_value` = that same address and `wb_en` = 1.
- R10: `wb_en` is 0 for every mode other than 5 and 6, and whenever the request was not valid. Mode code 7 is reserved and behaves as register-indirect with no update.
- R11: Access size code 0/1/2/3 means 1/2/4/8 bytes. `align_fault` is 1 exactly when the low 0/1/2/3 address bits are not all zero. The fault never alters `eff_addr`.
- R12: All sums wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing-mode code |
| base | input | ADDR_W | Base register value |
| index | input | ADDR_W | Index register value |
| scale | input | 2 | Index left-shift amount |
| disp | input | 32 | Displacement field |
| disp_size | input | 2 | Displacement width code |
| acc_size | input | 2 | Access size code |
| out_valid | output | 1 | Results valid |
| eff_addr | output | ADDR_W | Effective address |
| wb_en | output | 1 | Base update enable |
| wb_value | output | ADDR_W | New base value |
| align_fault | output | 1 | Address misaligned for access size |

## Verification
The assertions assume that `in_valid`, `mode`, `disp_size` and `acc_size` are known (never X) whenever reset is low. They also assume that a request's operands are sampled on the same edge that sees `in_valid`. The bench drives every input field on the falling edge from a seeded random source and mask-limits the codes to their legal two- or three-bit ranges. It also issues directed requests at the wrap and sign boundaries, so that every mode code, including the reserved one, is reached with defined operands.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_ABS     = 3'd0,
    AM_REGIND  = 3'd1,
    AM_DISP    = 3'd2,
    AM_INDEX   = 3'd3,
    AM_SCALED  = 3'd4,
    AM_POSTINC = 3'd5,
    AM_PREUPD  = 3'd6,
    AM_RSVD    = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    DS_8    = 2'd0,
    DS_16   = 2'd1,
    DS_32   = 2'd2,
    DS_NONE = 2'd3
  } dsize_e;

  localparam int DISP_W = 32;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        dsize,
  output logic [ADDR_W-1:0] disp_ext
);
  always_comb begin
    unique case (dsize_e'(dsize))
      DS_8:    disp_ext = ADDR_W'($signed(disp[7:0]));
      DS_16:   disp_ext = ADDR_W'($signed(disp[15:0]));
      DS_32:   disp_ext = ADDR_W'($signed(disp));
      default: disp_ext = '0;
    endcase
  end
endmodule

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  logic [ADDR_W-1:0]  index,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic               use_shift,
  output logic [ADDR_W-1:0]  index_out
);
  always_comb begin
    if (use_shift) index_out = index << shamt;
    else           index_out = index;
  end
endmodule

// File: rtl/agu_align_check.sv
module agu_align_check #(
  parameter int SIZE_CODES = 4
) (
  input  logic [SIZE_CODES-2:0]         addr_lsb,
  input  logic [$clog2(SIZE_CODES)-1:0] size_code,
  output logic                          misaligned
);
  localparam int LSB_W = SIZE_CODES - 1;
  logic [LSB_W-1:0] mask;

  generate
    for (genvar b = 0; b < LSB_W; b++) begin : g_mask
      assign mask[b] = (int'(size_code) > b);
    end
  endgenerate

  assign misaligned = |(addr_lsb & mask);
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [1:0]        scale,
  input  logic [31:0]       disp,
  input  logic [1:0]        disp_size,
  input  logic [1:0]        acc_size,
  output logic              out_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value,
  output logic              align_fault
);
  localparam int SIZE_CODES = 4;
  localparam int LSB_W      = SIZE_CODES - 1;

  amode_e            am;
  logic [ADDR_W-1:0] disp_ext, idx_sc;
  logic [ADDR_W-1:0] op_a, op_b, op_c, sum, wb_c;
  logic              use_base, use_idx, use_disp, is_auto, fault_c;

  assign am = amode_e'(mode);

  agu_disp_ext #(.ADDR_W(ADDR_W)) u_dext (
    .disp(disp), .dsize(disp_size), .disp_ext(disp_ext)
  );

  agu_index_scale #(.ADDR_W(ADDR_W), .SHIFT_W(2)) u_scale (
    .index(index), .shamt(scale), .use_shift(am == AM_SCALED), .index_out(idx_sc)
  );

  always_comb begin
    use_base = 1'b1;
    use_idx  = 1'b0;
    use_disp = 1'b0;
    is_auto  = 1'b0;
    unique case (am)
      AM_ABS:     begin use_base = 1'b0; use_disp = 1'b1; end
      AM_DISP:    use_disp = 1'b1;
      AM_INDEX:   use_idx  = 1'b1;
      AM_SCALED:  begin use_idx = 1'b1; use_disp = 1'b1; end
      AM_POSTINC: is_auto  = 1'b1;
      AM_PREUPD:  begin use_disp = 1'b1; is_auto = 1'b1; end
      default:    ;
    endcase
  end

  assign op_a = use_base ? base     : '0;
  assign op_b = use_idx  ? idx_sc   : '0;
  assign op_c = use_disp ? disp_ext : '0;
  assign sum  = op_a + op_b + op_c;
  assign wb_c = (am == AM_POSTINC) ? base + ADDR_W'(1) : sum;

  agu_align_check #(.SIZE_CODES(SIZE_CODES)) u_align (
    .addr_lsb(sum[LSB_W-1:0]), .size_code(acc_size), .misaligned(fault_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      wb_en       <= 1'b0;
      align_fault <= 1'b0;
      eff_addr    <= '0;
      wb_value    <= '0;
    end else begin
      out_valid   <= in_valid;
      wb_en       <= in_valid & is_auto;
      align_fault <= in_valid & fault_c;
      if (in_valid) begin
        eff_addr <= sum;
        wb_value <= wb_c;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wb_en && !align_fault));

  a_r3_regind_base: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd1) |=> (eff_addr == $past(base) && !wb_en));

  a_r2_abs_full_disp: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd0 && disp_size == 2'd2) |=> (eff_addr == ADDR_W'($signed($past(disp)))));

  a_r8_postinc_update: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd5) |=> (wb_en && eff_addr == $past(base) && wb_value == $past(base) + ADDR_W'(1)));

  a_r9_preupd_same: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd6) |=> (wb_en && wb_value == eff_addr));

  a_r10_no_update: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode != 3'd5 && mode != 3'd6) |=> !wb_en);

  a_r11_byte_never_faults: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_size == 2'd0) |=> !align_fault);
endmodule

// File: tb/addr_gen_unit_tb_top.sv
module addr_gen_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  mode;
  logic [31:0] base, index, disp;
  logic [1:0]  scale, disp_size, acc_size;
  logic        out_valid, wb_en, align_fault;
  logic [31:0] eff_addr, wb_value;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  addr_gen_unit #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base(base),
    .index(index), .scale(scale), .disp(disp), .disp_size(disp_size),
    .acc_size(acc_size), .out_valid(out_valid), .eff_addr(eff_addr),
    .wb_en(wb_en), .wb_value(wb_value), .align_fault(align_fault)
  );

  function automatic logic [31:0] sext(logic [31:0] d, logic [1:0] sz);
    case (sz)
      2'd0:    return {{24{d[7]}}, d[7:0]};
      2'd1:    return {{16{d[15]}}, d[15:0]};
      2'd2:    return d;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(logic [2:0] m, logic [31:0] b, logic [31:0] x,
                                           logic [1:0] s, logic [31:0] d, logic [1:0] dz);
    logic [31:0] e;
    e = sext(d, dz);
    case (m)
      3'd0: return e;
      3'd2: return b + e;
      3'd3: return b + x;
      3'd4: return b + x * (32'd1 << s) + e;
      3'd6: return b + e;
      default: return b;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd0: return "R2/R7";
      3'd1: return "R3";
      3'd2: return "R4/R7";
      3'd3: return "R5";
      3'd4: return "R6/R7";
      3'd5: return "R8";
      3'd6: return "R9/R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic run_one(logic [2:0] m, logic [31:0] b, logic [31:0] x, logic [1:0] s,
                         logic [31:0] d, logic [1:0] dz, logic [1:0] az);
    logic [31:0] ea, wbv;
    logic        auto_m, flt;
    in_valid = 1'b1; mode = m; base = b; index = x; scale = s;
    disp = d; disp_size = dz; acc_size = az;
    ea     = exp_addr(m, b, x, s, d, dz);
    auto_m = (m == 3'd5) || (m == 3'd6);
    wbv    = (m == 3'd5) ? b + 32'd1 : ea;
    flt    = (ea % (32'd1 << az)) != 32'd0;
    @(negedge clk);
    chk("R1", "out_valid", 32'(out_valid), 32'd1);
    chk(req_of(m), "eff_addr", eff_addr, ea);
    chk(auto_m ? req_of(m) : "R10", "wb_en", 32'(wb_en), 32'(auto_m));
    if (auto_m) chk(req_of(m), "wb_value", wb_value, wbv);
    chk("R11", "align_fault", 32'(align_fault), 32'(flt));
  endtask

  task automatic run_idle(logic [2:0] m);
    in_valid = 1'b0; mode = m;
    @(negedge clk);
    chk("R1", "out_valid idle", 32'(out_valid), 32'd0);
    chk("R10", "wb_en idle", 32'(wb_en), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; mode = '0; base = '0; index = '0;
    scale = '0; disp = '0; disp_size = '0; acc_size = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", 32'(out_valid), 32'd0);
    chk("R1", "reset wb_en", 32'(wb_en), 32'd0);
    chk("R1", "reset align_fault", 32'(align_fault), 32'd0);
    chk("R1", "reset eff_addr", eff_addr, 32'd0);
    chk("R1", "reset wb_value", wb_value, 32'd0);
    rst = 1'b0;

    // Directed corners
    run_one(3'd0, 32'h1234_5678, 32'd0, 2'd0, 32'h0000_0080, 2'd0, 2'd0); // R7 -128
    run_one(3'd0, 32'd0, 32'd0, 2'd0, 32'hABCD_8000, 2'd1, 2'd0);         // R7 16-bit neg
    run_one(3'd2, 32'h0000_1000, 32'd0, 2'd0, 32'hFFFF_FF7F, 2'd3, 2'd2); // R7 none
    run_one(3'd3, 32'h0000_0100, 32'h10, 2'd3, 32'd0, 2'd2, 2'd0);         // R5 no scale
    run_one(3'd4, 32'h0000_0100, 32'h10, 2'd3, 32'h4, 2'd0, 2'd2);         // R6 x8
    run_one(3'd5, 32'hFFFF_FFFF, 32'd0, 2'd0, 32'd0, 2'd0, 2'd0);          // R8/R12 wrap
    run_one(3'd6, 32'h0000_0010, 32'd0, 2'd0, 32'h0000_00F0, 2'd0, 2'd1);  // R9 back 16
    run_one(3'd7, 32'h0000_0045, 32'd9, 2'd1, 32'd7, 2'd2, 2'd0);          // R10 reserved
    run_one(3'd1, 32'h0000_0003, 32'd0, 2'd0, 32'd0, 2'd0, 2'd1);          // R11 half odd
    run_one(3'd1, 32'h0000_0004, 32'd0, 2'd0, 32'd0, 2'd0, 2'd2);          // R11 word ok
    run_one(3'd1, 32'h0000_0004, 32'd0, 2'd0, 32'd0, 2'd0, 2'd3);          // R11 dword bad
    run_one(3'd2, 32'hFFFF_FFF0, 32'd0, 2'd0, 32'h0000_0020, 2'd2, 2'd0);  // R12 wrap
    run_idle(3'd5);
    run_idle(3'd6);

    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) run_idle(3'($urandom));
      else run_one(3'($urandom), $urandom, $urandom, 2'($urandom), $urandom,
                   2'($urandom), 2'($urandom));
    end

    rst = 1'b1;
    @(negedge clk);
    chk("R1", "re-reset out_valid", 32'(out_valid), 32'd0);
    chk("R1", "re-reset eff_addr", eff_addr, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule